// File: doc/BRIEF.md
# Periodic Compare Timer with Keyed Auto-Clear

The block runs one free-running up-counter and compares it against four independent channels. Each channel holds a compare point, a step, and a clear point. When the counter reaches the compare point, the channel does three things: it raises its pending flag, emits a single-cycle trigger, and moves its compare point forward by the step. This gives a fixed-period event stream from a single time base. Each channel can also be armed to drop its own flag in hardware when the counter reaches the clear point. The clear point then moves forward by the same step, so the flag stays high for a fixed window of counts in every period.

Hardware consumers such as converters or transfer engines use the self-clearing flag. Software-serviced interrupts use the plain flag, which software clears by writing 1 to its bit. Auto-clear takes effect only when a channel's 4-bit key field holds 0xA. With auto-clear on, the interrupt line may fall before any handler runs, so that combination suits hardware triggers only. All registers sit behind a plain synchronous write/read port.

Top module: `cmp_timer`

## Requirements
- R1: After reset, every register reads 0, and trig_o and irq_o are 0.
- R2: The counter (address 0x01, writable) rises by one on each clock edge while the run bit (bit 0 of address 0x00) is 1. It holds while the run bit is 0 and wraps from 0xFFFFFFFF to 0. Compares use the value held before the increment.
- R3: When the run bit is 1 and the counter equals channel k's compare point, flag bit k is set and trig_o[k] is high for exactly the following cycle.
- R4: On each match, channel k's compare point advances by its step, modulo 2^32.
- R5: Auto-clear for channel k is armed only when bits [4k+3:4k] of address 0x04 hold 0xA. When armed and running, the flag clears when the counter equals the clear point. Any other key value leaves the flag set.
- R6: After each auto-clear, the clear point advances by the channel's step.
- R7: Address 0x02 holds the flags in bits [3:0] and is write-1-to-clear. A written 0 leaves a flag unchanged. Clearing this way works whether or not auto-clear is armed.
- R8: irq_o[k] is flag k ANDed with bit k of the interrupt-enable register (address 0x03).
- R9: If a match and a clear (software or automatic) hit the same channel in the same cycle, the flag ends up set.
- R10: rdata_o shows the register selected by addr_i one cycle after the address is presented. Channel k occupies 0x08+4k (compare point), 0x09+4k (step) and 0x0A+4k (clear point).
- R11: While the run bit is 0, no channel matches, even if the counter equals its compare point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| trig_o | output | 4 | Per-channel one-cycle match pulses |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
A counter value compared at a clock edge produces its flag, trigger and interrupt changes in the cycle right after that edge. After an edge that writes the run bit, the counter holds the same value once more before it starts stepping. Each test therefore starts the counter from a known value and waits a computed number of edges. It samples trig_o and irq_o on the falling edge just after the edge that compared the value of interest. Register reads return one cycle after the address and are issued only while the counter is stopped or with the extra edge counted in.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_CNT     = 1;
  localparam int unsigned A_FLAG    = 2;
  localparam int unsigned A_IE      = 3;
  localparam int unsigned A_KEY     = 4;
  localparam int unsigned A_CH0     = 8;
  localparam int unsigned CH_STRIDE = 4;
  localparam int unsigned OFF_CMP   = 0;
  localparam int unsigned OFF_STEP  = 1;
  localparam int unsigned OFF_CLR   = 2;
  localparam logic [3:0]  AC_KEY    = 4'hA;
endpackage

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (run_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_cmp_i,
  input  logic             wr_step_i,
  input  logic             wr_clr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ac_en_i,
  input  logic             sw_clr_i,
  output logic             flag_o,
  output logic             trig_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CNT_W-1:0] step_o,
  output logic [CNT_W-1:0] clr_o
);
  logic hit, ac_hit;

  assign hit    = run_i && (cnt_i == cmp_o);
  assign ac_hit = run_i && ac_en_i && (cnt_i == clr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      trig_o <= 1'b0;
      cmp_o  <= '0;
      step_o <= '0;
      clr_o  <= '0;
    end else begin
      trig_o <= hit;
      // set has priority over any clear
      if (hit)                     flag_o <= 1'b1;
      else if (sw_clr_i || ac_hit) flag_o <= 1'b0;
      if (wr_cmp_i)  cmp_o <= wdata_i;
      else if (hit)  cmp_o <= cmp_o + step_o;
      if (wr_step_i) step_o <= wdata_i;
      if (wr_clr_i)    clr_o <= wdata_i;
      else if (ac_hit) clr_o <= clr_o + step_o;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   trig_o,
  output logic [N_CH-1:0]   irq_o
);
  localparam int unsigned KEY_W = 4 * N_CH;

  logic                        run_q;
  logic [N_CH-1:0]             ie_q;
  logic [KEY_W-1:0]            key_q;
  logic [CNT_W-1:0]            cnt_q;
  logic                        cnt_wr;
  logic [N_CH-1:0]             flag_q, cmp_wr, step_wr, clr_wr, ac_en, sw_clr;
  logic [N_CH-1:0][CNT_W-1:0]  cmp_all, step_all, clr_all;
  logic [CNT_W-1:0]            rd_nxt;

  assign cnt_wr = we_i && (addr_i == ADDR_W'(A_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ie_q  <= '0;
      key_q <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_CTRL)) run_q <= wdata_i[0];
      if (addr_i == ADDR_W'(A_IE))   ie_q  <= wdata_i[N_CH-1:0];
      if (addr_i == ADDR_W'(A_KEY))  key_q <= wdata_i[KEY_W-1:0];
    end
  end

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam int unsigned BASE = A_CH0 + CH_STRIDE * k;
    assign cmp_wr[k]  = we_i && (addr_i == ADDR_W'(BASE + OFF_CMP));
    assign step_wr[k] = we_i && (addr_i == ADDR_W'(BASE + OFF_STEP));
    assign clr_wr[k]  = we_i && (addr_i == ADDR_W'(BASE + OFF_CLR));
    assign sw_clr[k]  = we_i && (addr_i == ADDR_W'(A_FLAG)) && wdata_i[k];
    assign ac_en[k]   = (key_q[4*k +: 4] == AC_KEY);

    cmp_timer_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_q),
      .cnt_i     (cnt_q),
      .wr_cmp_i  (cmp_wr[k]),
      .wr_step_i (step_wr[k]),
      .wr_clr_i  (clr_wr[k]),
      .wdata_i   (wdata_i),
      .ac_en_i   (ac_en[k]),
      .sw_clr_i  (sw_clr[k]),
      .flag_o    (flag_q[k]),
      .trig_o    (trig_o[k]),
      .cmp_o     (cmp_all[k]),
      .step_o    (step_all[k]),
      .clr_o     (clr_all[k])
    );
  end

  assign irq_o = flag_q & ie_q;

  always_comb begin
    rd_nxt = '0;
    if (addr_i == ADDR_W'(A_CTRL)) rd_nxt = CNT_W'(run_q);
    if (addr_i == ADDR_W'(A_CNT))  rd_nxt = cnt_q;
    if (addr_i == ADDR_W'(A_FLAG)) rd_nxt = CNT_W'(flag_q);
    if (addr_i == ADDR_W'(A_IE))   rd_nxt = CNT_W'(ie_q);
    if (addr_i == ADDR_W'(A_KEY))  rd_nxt = CNT_W'(key_q);
    for (int k = 0; k < N_CH; k++) begin
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * k + OFF_CMP))  rd_nxt = cmp_all[k];
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * k + OFF_STEP)) rd_nxt = step_all[k];
      if (addr_i == ADDR_W'(A_CH0 + CH_STRIDE * k + OFF_CLR))  rd_nxt = clr_all[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_nxt;
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       run_q,
  input logic                       cnt_wr,
  input logic [CNT_W-1:0]           cnt_q,
  input logic [N_CH-1:0]            flag_q,
  input logic [N_CH-1:0]            trig_o,
  input logic [N_CH-1:0]            cmp_wr,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_all,
  input logic [N_CH-1:0][CNT_W-1:0] step_all
);
  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_q) && !$past(cnt_wr)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_count_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_q) && !$past(cnt_wr)) |-> $stable(cnt_q));

  p_no_match_stopped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_q) |-> (trig_o == '0));

  p_trig_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((trig_o & ~flag_q) == '0));

  for (genvar k = 0; k < N_CH; k++) begin : g_a
    p_cmp_advance_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_o[k] && !$past(cmp_wr[k])) |->
        (cmp_all[k] == $past(cmp_all[k]) + $past(step_all[k])));
  end
endmodule

bind cmp_timer cmp_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_q    (run_q),
  .cnt_wr   (cnt_wr),
  .cnt_q    (cnt_q),
  .flag_q   (flag_q),
  .trig_o   (trig_o),
  .cmp_wr   (cmp_wr),
  .cmp_all  (cmp_all),
  .step_all (step_all)
);

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  trig_o, irq_o;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cmp_timer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .trig_o(trig_o), .irq_o(irq_o)
  );

  localparam logic [4:0] A_CTRL = 5'h00, A_CNT = 5'h01, A_FLAG = 5'h02,
                         A_IE = 5'h03, A_KEY = 5'h04;
  function automatic logic [4:0] a_cmp(int k);  return 5'(8 + 4*k); endfunction
  function automatic logic [4:0] a_step(int k); return 5'(9 + 4*k); endfunction
  function automatic logic [4:0] a_clr(int k);  return 5'(10 + 4*k); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    @(posedge clk_i); @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic prep(int k, logic [31:0] cmp, logic [31:0] step, logic [31:0] clr,
                      logic [31:0] key, logic [31:0] ie, logic [31:0] cnt);
    wr(A_CTRL, 0);
    wr(A_FLAG, 32'hF);
    wr(a_cmp(k), cmp); wr(a_step(k), step); wr(a_clr(k), clr);
    wr(A_KEY, key); wr(A_IE, ie); wr(A_CNT, cnt);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 trig", 32'(trig_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(A_CNT, d);     chk("R1 cnt", d, 0);
    rd(A_CTRL, d);    chk("R1 ctrl", d, 0);
    rd(a_cmp(3), d);  chk("R1 cmp3", d, 0);
    rd(a_clr(1), d);  chk("R1 clr1", d, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] d;
    prep(1, 4, 6, 32'hFFFF, 0, 32'h2, 0);
    wr(A_CTRL, 1);
    tick(4);
    chk("R3 no early trig", 32'(trig_o[1]), 0);
    tick(1);
    chk("R3 trig at 4", 32'(trig_o[1]), 1);
    chk("R8 irq follows flag", 32'(irq_o), 32'h2);
    tick(1);
    chk("R3 trig one cycle", 32'(trig_o[1]), 0);
    chk("R3 flag held", 32'(irq_o[1]), 1);
    tick(4);
    chk("R4 no trig before 10", 32'(trig_o[1]), 0);
    tick(1);
    chk("R4 trig at 10", 32'(trig_o[1]), 1);
    wr(A_CTRL, 0);
    rd(a_cmp(1), d);  chk("R4 cmp advanced", d, 16);
    wr(A_FLAG, 0);
    chk("R7 zero write keeps flag", 32'(irq_o[1]), 1);
    wr(A_FLAG, 32'h2);
    chk("R7 w1c clears", 32'(irq_o[1]), 0);
    wr(A_IE, 0);
    wr(A_CTRL, 1); wr(A_CTRL, 0);
    rd(A_FLAG, d);
    chk("R8 masked irq", 32'(irq_o), 0);
  endtask

  task automatic t_autoclear();
    logic [31:0] d;
    prep(0, 3, 8, 6, 32'h000A, 32'h1, 0);
    wr(A_CTRL, 1);
    tick(4);  chk("R5 set at 3", 32'(irq_o[0]), 1);
    tick(2);  chk("R5 held at 5", 32'(irq_o[0]), 1);
    tick(1);  chk("R5 auto-clear at 6", 32'(irq_o[0]), 0);
    tick(5);  chk("R5 set at 11", 32'(irq_o[0]), 1);
    tick(3);  chk("R6 auto-clear at 14", 32'(irq_o[0]), 0);
    wr(A_CTRL, 0);
    rd(a_clr(0), d);  chk("R6 clr advanced", d, 22);
    rd(A_KEY, d);     chk("R10 key readback", d, 32'h000A);
    rd(A_IE, d);      chk("R10 ie readback", d, 32'h1);
  endtask

  task automatic t_wrong_key();
    prep(0, 3, 8, 6, 32'h0005, 32'h1, 0);
    wr(A_CTRL, 1);
    tick(8);  chk("R5 wrong key keeps flag", 32'(irq_o[0]), 1);
    wr(A_KEY, 32'h000A);
    wr(A_FLAG, 32'h1);
    chk("R7 sw clear with key armed", 32'(irq_o[0]), 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_set_wins();
    prep(2, 5, 100, 5, 32'h0A00, 32'h4, 0);
    wr(A_CTRL, 1);
    tick(6);  chk("R9 match beats auto-clear", 32'(irq_o[2]), 1);
    prep(2, 5, 100, 50, 32'h0, 32'h4, 0);
    wr(A_CTRL, 1);
    tick(5);
    wr(A_FLAG, 32'h4);
    chk("R9 match beats sw clear", 32'(irq_o[2]), 1);
    wr(A_FLAG, 32'h4);
    chk("R9 later sw clear", 32'(irq_o[2]), 0);
    wr(A_CTRL, 0);
  endtask

  task automatic t_wrap_stop();
    logic [31:0] d;
    prep(3, 0, 3, 32'hFFFF, 0, 32'h8, 32'hFFFF_FFFE);
    wr(A_CTRL, 1);
    tick(2);  chk("R2 no trig before wrap", 32'(trig_o[3]), 0);
    tick(1);  chk("R2 trig at wrapped 0", 32'(trig_o[3]), 1);
    wr(A_CTRL, 0);
    rd(A_CNT, d);     chk("R2 wrapped count", d, 2);
    rd(a_cmp(3), d);  chk("R4 cmp after wrap", d, 3);
    wr(A_FLAG, 32'hF);
    wr(a_cmp(3), 2);
    tick(6);
    chk("R11 no match stopped", 32'(irq_o[3]), 0);
    rd(A_CNT, d);     chk("R2 count held", d, 2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_periodic();
    t_autoclear();
    t_wrong_key();
    t_set_wins();
    t_wrap_stop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule